// File: doc/BRIEF.md
# Acquisition Event Flag and Interrupt Unit

This block collects the events of one parallel digital input acquisition group into a byte of flags. It raises an interrupt for the events that software has enabled. Hardware pulses set the sticky flags for a wait condition, a primary terminal count and a secondary terminal count. An internal transfer counter sets the count-expired flag. The transfer-ready flag is not stored: it follows the input FIFO's non-empty level and drops by itself once reads drain the FIFO.

Software reaches the block over a byte-wide register port. Writes are synchronous and reads are combinational. Flags are write-one-to-clear through two clear registers whose bit positions differ from the flag positions. The first clear register also carries two one-shot strobes that reset the DMA engine and the FIFO. A summary status bit tells an interrupt service loop whether enabled work is still pending. A two-bit line select in the master control register routes the registered interrupt onto one of several lines, or onto none.

Register offsets: 0 summary status (read), 1 flags (read), 2 first clear (write), 3 second clear (write), 4 interrupt enable (read/write), 5 master control (read/write), 8 upward transfer count bytes, least significant byte first (read/write).

Top module: `acq_evt_irq`

## Requirements
- R1: Flags byte (offset 1) bit 0 is transfer-ready. It equals fifo_nonempty combinationally and no clear write affects it.
- R2: A one-cycle pulse on wait_evt, ptc_evt or stc_evt sets flag bit 5, 6 or 7 at that clock edge. The flag stays set until it is cleared.
- R3: Writing offset 2 clears the waited, primary-TC and secondary-TC flags with data bits 3, 4 and 5 respectively (write one to clear). Zero bits have no effect, and count-expired (flag bit 1) is never cleared by this register.
- R4: Writing offset 3 with data bit 0 set clears count-expired and no other flag.
- R5: When a flag's set event and its clear land in the same cycle, the flag ends set.
- R6: Writing offset 2 with data bit 6 set makes dma_rst high for exactly the one cycle after the write. Data bit 7 does the same for fifo_rst.
- R7: The transfer count is loaded byte by byte at offsets 8 upward, least significant byte first, and reads back at the same offsets. Each cycle with sample high decrements it by one, with full borrow across bytes. At zero it holds.
- R8: Count-expired (flag bit 1) sets at the edge where a sample takes the count from 1 to 0. A count of zero never sets it.
- R9: The interrupt enable byte (offset 4) uses the flag bit positions. Summary status (offset 0) bit 0 is 1 exactly when some enabled flag is set, and its other bits read 0.
- R10: Master control bits 1:0 (offset 5) hold a line select k. For k from 1 to IRQ_LINES, irq[k-1] follows the summary bit one clock later and the other lines stay low. k = 0 keeps all lines low.
- R11: After reset, all flags, the enable byte, the line select, the count, the strobes and the irq lines are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write offset |
| wr_data | input | REG_W | Write data |
| rd_addr | input | ADDR_W | Read offset |
| rd_data | output | REG_W | Read data, combinational |
| fifo_nonempty | input | 1 | Input FIFO holds data |
| sample | input | 1 | One sample accepted this cycle |
| wait_evt | input | 1 | Wait condition event pulse |
| ptc_evt | input | 1 | Primary terminal count pulse |
| stc_evt | input | 1 | Secondary terminal count pulse |
| dma_rst | output | 1 | One-cycle DMA reset strobe |
| fifo_rst | output | 1 | One-cycle FIFO reset strobe |
| irq | output | IRQ_LINES | Interrupt request lines |

## Verification
Two functions can fall in the same cycle: a flag's set event and the software clear of that flag. This happens for the primary-TC pulse against a first-clear write, and for the final count decrement against a second-clear write. The bench drives both inputs in the same cycle and then reads the flags byte, which must still show the flag. It also writes clear bytes with zero bits in the positions of flags that are set, and checks that those flags survive at the ports.

// File: rtl/acq_evt_pkg.sv
package acq_evt_pkg;
   localparam int FLG_W = 8;
   // flag byte positions (software decodes these)
   localparam int B_RDY  = 0;
   localparam int B_EXP  = 1;
   localparam int B_WAIT = 5;
   localparam int B_PTC  = 6;
   localparam int B_STC  = 7;
   // first clear register positions
   localparam int C1_WAIT = 3;
   localparam int C1_PTC  = 4;
   localparam int C1_STC  = 5;
   localparam int C1_DMA  = 6;
   localparam int C1_FIFO = 7;
   // second clear register position
   localparam int C2_EXP  = 0;
   // which flag bits are stored
   localparam logic [FLG_W-1:0] STICKY_MASK = 8'hE2;
   // register offsets
   localparam int A_STAT  = 0;
   localparam int A_FLAGS = 1;
   localparam int A_CLR1  = 2;
   localparam int A_CLR2  = 3;
   localparam int A_IEN   = 4;
   localparam int A_MCTL  = 5;
   localparam int A_CNT0  = 8;
endpackage

// File: rtl/acq_flag_bank.sv
module acq_flag_bank #(
   parameter int               W    = 8,
   parameter logic [W-1:0]     KEEP = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_v,
   input  logic [W-1:0] clr_v,
   output logic [W-1:0] flag_o
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      if (KEEP[i]) begin : g_keep
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= set_v[i] | (q & ~clr_v[i]);
         end
         assign flag_o[i] = q;

         // R5: a set event is never lost to a simultaneous clear
         p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
            set_v[i] |=> flag_o[i]);
         // R2: flag holds until cleared
         p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
            flag_o[i] && !clr_v[i] |=> flag_o[i]);
         // R3: a clear with no set empties the flag
         p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
            clr_v[i] && !set_v[i] |=> !flag_o[i]);
      end else begin : g_none
         logic unused_bit;
         assign unused_bit = set_v[i] ^ clr_v[i];
         assign flag_o[i]  = 1'b0;
      end
   end
endmodule

// File: rtl/acq_xfer_cnt.sv
module acq_xfer_cnt #(
   parameter int CNT_W  = 32,
   parameter int LANE_W = 8,
   localparam int NL    = CNT_W / LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NL-1:0]     lane_we,
   input  logic [LANE_W-1:0] lane_d,
   input  logic              sample,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              expire_o
);
   logic [CNT_W-1:0] cnt_q, cnt_n;
   logic             load;

   assign load = |lane_we;

   always_comb begin
      cnt_n = cnt_q;
      if (load) begin
         for (int l = 0; l < NL; l++)
            if (lane_we[l]) cnt_n[l*LANE_W +: LANE_W] = lane_d;
      end else if (sample && cnt_q != '0) begin
         cnt_n = cnt_q - CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_n;
   end

   assign cnt_o    = cnt_q;
   assign expire_o = sample && !load && (cnt_q == CNT_W'(1));

   // R7: an idle zero count stays at zero
   p_hold_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q == '0 && !load |=> cnt_q == '0);
   // R7: one decrement per accepted sample
   p_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sample && !load && cnt_q != '0 |=> cnt_q == $past(cnt_q) - CNT_W'(1));
   // R8: expiry lands exactly on the count reaching zero
   p_expire_r8: assert property (@(posedge clk) disable iff (!rst_n)
      expire_o |=> cnt_q == '0);
endmodule

// File: rtl/acq_irq_route.sv
module acq_irq_route #(
   parameter int FLG_W = 8,
   parameter int LINES = 3,
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [FLG_W-1:0] flags_i,
   input  logic [FLG_W-1:0] ien_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             pending_o,
   output logic [LINES-1:0] irq_o
);
   assign pending_o = |(flags_i & ien_i);

   for (genvar i = 0; i < LINES; i++) begin : g_line
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 1'b0;
         else        q <= pending_o && (sel_i == SEL_W'(i + 1));
      end
      assign irq_o[i] = q;
   end

   // R10: a zero select silences every line
   p_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sel_i == '0 |=> irq_o == '0);
   // R10: at most one line is driven
   p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_o));
   // R10: line 1 follows pending one clock later
   p_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pending_o && sel_i == SEL_W'(1) |=> irq_o[0]);
endmodule

// File: rtl/acq_evt_irq.sv
module acq_evt_irq
   import acq_evt_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int REG_W     = 8,
   parameter int CNT_W     = 32,
   parameter int IRQ_LINES = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [REG_W-1:0]     wr_data,
   input  logic [ADDR_W-1:0]    rd_addr,
   output logic [REG_W-1:0]     rd_data,
   input  logic                 fifo_nonempty,
   input  logic                 sample,
   input  logic                 wait_evt,
   input  logic                 ptc_evt,
   input  logic                 stc_evt,
   output logic                 dma_rst,
   output logic                 fifo_rst,
   output logic [IRQ_LINES-1:0] irq
);
   localparam int SEL_W = 2;
   localparam int NL    = CNT_W / REG_W;

   if (REG_W != FLG_W) begin : g_bad_reg
      $error("REG_W must equal the flag byte width");
   end
   if (CNT_W % REG_W != 0 || CNT_W < REG_W) begin : g_bad_cnt
      $error("CNT_W must be a nonzero multiple of REG_W");
   end
   if (A_CNT0 + NL > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for the count bytes");
   end
   if (IRQ_LINES < 1 || IRQ_LINES > 3) begin : g_bad_irq
      $error("IRQ_LINES must be 1 to 3");
   end

   logic             clr1_we, clr2_we;
   logic [FLG_W-1:0] set_v, clr_v, stk, flags;
   logic [FLG_W-1:0] ien_q;
   logic [SEL_W-1:0] sel_q;
   logic [NL-1:0]    lane_we;
   logic [CNT_W-1:0] cnt;
   logic             expire, pending;
   logic             dma_q, fifo_q;

   assign clr1_we = wr_en && (wr_addr == ADDR_W'(A_CLR1));
   assign clr2_we = wr_en && (wr_addr == ADDR_W'(A_CLR2));

   for (genvar l = 0; l < NL; l++) begin : g_lane
      assign lane_we[l] = wr_en && (wr_addr == ADDR_W'(A_CNT0 + l));
   end

   always_comb begin
      set_v         = '0;
      set_v[B_EXP]  = expire;
      set_v[B_WAIT] = wait_evt;
      set_v[B_PTC]  = ptc_evt;
      set_v[B_STC]  = stc_evt;
      clr_v         = '0;
      clr_v[B_EXP]  = clr2_we && wr_data[C2_EXP];
      clr_v[B_WAIT] = clr1_we && wr_data[C1_WAIT];
      clr_v[B_PTC]  = clr1_we && wr_data[C1_PTC];
      clr_v[B_STC]  = clr1_we && wr_data[C1_STC];
   end

   acq_flag_bank #(.W(FLG_W), .KEEP(STICKY_MASK)) u_flags (
      .clk(clk), .rst_n(rst_n), .set_v(set_v), .clr_v(clr_v), .flag_o(stk));

   always_comb begin
      flags        = stk;
      flags[B_RDY] = fifo_nonempty;
   end

   acq_xfer_cnt #(.CNT_W(CNT_W), .LANE_W(REG_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .lane_we(lane_we), .lane_d(wr_data),
      .sample(sample), .cnt_o(cnt), .expire_o(expire));

   acq_irq_route #(.FLG_W(FLG_W), .LINES(IRQ_LINES), .SEL_W(SEL_W)) u_irq (
      .clk(clk), .rst_n(rst_n), .flags_i(flags), .ien_i(ien_q), .sel_i(sel_q),
      .pending_o(pending), .irq_o(irq));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q  <= '0;
         sel_q  <= '0;
         dma_q  <= 1'b0;
         fifo_q <= 1'b0;
      end else begin
         if (wr_en && wr_addr == ADDR_W'(A_IEN))  ien_q <= wr_data;
         if (wr_en && wr_addr == ADDR_W'(A_MCTL)) sel_q <= wr_data[SEL_W-1:0];
         dma_q  <= clr1_we && wr_data[C1_DMA];
         fifo_q <= clr1_we && wr_data[C1_FIFO];
      end
   end

   assign dma_rst  = dma_q;
   assign fifo_rst = fifo_q;

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         ADDR_W'(A_STAT):  rd_data[0] = pending;
         ADDR_W'(A_FLAGS): rd_data = flags;
         ADDR_W'(A_IEN):   rd_data = ien_q;
         ADDR_W'(A_MCTL):  rd_data[SEL_W-1:0] = sel_q;
         default: begin
            for (int l = 0; l < NL; l++)
               if (rd_addr == ADDR_W'(A_CNT0 + l)) rd_data = cnt[l*REG_W +: REG_W];
         end
      endcase
   end

   // R6: each strobe traces back to a matching clear write
   p_dma_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dma_rst |-> $past(wr_en && wr_addr == ADDR_W'(A_CLR1) && wr_data[C1_DMA]));
   p_fifo_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rst |-> $past(wr_en && wr_addr == ADDR_W'(A_CLR1) && wr_data[C1_FIFO]));
   // R3: the first clear register leaves count-expired alone
   p_exp_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      stk[B_EXP] && !clr2_we |=> stk[B_EXP]);
   // R1: transfer-ready mirrors the FIFO level
   p_rdy_r1: assert property (@(posedge clk) disable iff (!rst_n)
      flags[B_RDY] == fifo_nonempty);
endmodule

// File: tb/acq_evt_irq_bench.sv
module acq_evt_irq_bench;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [3:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       fifo_ne = 1'b0, samp = 1'b0;
   logic       wt = 1'b0, ptc = 1'b0, stc = 1'b0;
   logic       dma_rst, fifo_rst;
   logic [2:0] irq;

   int n_run = 0, n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   acq_evt_irq u_acq_evt_irq (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .fifo_nonempty(fifo_ne), .sample(samp), .wait_evt(wt),
      .ptc_evt(ptc), .stc_evt(stc), .dma_rst(dma_rst),
      .fifo_rst(fifo_rst), .irq(irq));

   // {wr, addr[3:0], data[7:0], {stc,ptc,wt}, fifo, expected flags[7:0]}
   localparam logic [24:0] VEC [0:9] = '{
      {1'b0, 4'h0, 8'h00, 3'b001, 1'b0, 8'h20},   // R2 waited
      {1'b0, 4'h0, 8'h00, 3'b010, 1'b0, 8'h60},   // R2 primary TC
      {1'b0, 4'h0, 8'h00, 3'b100, 1'b1, 8'hE1},   // R2 secondary TC, R1 ready
      {1'b1, 4'h2, 8'h08, 3'b000, 1'b1, 8'hC1},   // R3 clear waited
      {1'b1, 4'h2, 8'h00, 3'b000, 1'b1, 8'hC1},   // R3 zero write no effect
      {1'b1, 4'h2, 8'h10, 3'b010, 1'b0, 8'hC0},   // R5 set beats clear
      {1'b1, 4'h2, 8'h30, 3'b000, 1'b0, 8'h00},   // R3 clear both TCs
      {1'b1, 4'h2, 8'hC0, 3'b001, 1'b0, 8'h20},   // R3 strobe bits clear nothing
      {1'b1, 4'h3, 8'h01, 3'b000, 1'b0, 8'h20},   // R4 second clear spares waited
      {1'b1, 4'h2, 8'h38, 3'b000, 1'b0, 8'h00}    // R3 clear all
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
      wr_en = 1'b0; wt = 1'b0; ptc = 1'b0; stc = 1'b0; samp = 1'b0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      tick();
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] v);
      rd_addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic rd_cnt(output logic [31:0] c);
      logic [7:0] b;
      for (int i = 0; i < 4; i++) begin
         rd(4'(8 + i), b);
         c[i*8 +: 8] = b;
      end
   endtask

   initial begin
      #(CLK_P * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [7:0]  v;
      logic [31:0] c;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;

      // R11 reset state
      rd(4'h1, v); chk("R11 flags", v, 8'h00);
      rd(4'h0, v); chk("R11 status", v, 8'h00);
      rd(4'h4, v); chk("R11 enable", v, 8'h00);
      rd(4'h5, v); chk("R11 select", v, 8'h00);
      rd_cnt(c);   chk("R11 count", c, 0);
      chk("R11 outputs", {27'd0, dma_rst, fifo_rst, irq}, 0);

      // vector walk over flag set/clear patterns
      for (int k = 0; k < 10; k++) begin
         fifo_ne = VEC[k][8];
         {stc, ptc, wt} = VEC[k][11:9];
         if (VEC[k][24]) begin
            wr_en = 1'b1; wr_addr = VEC[k][23:20]; wr_data = VEC[k][19:12];
         end
         tick();
         rd(4'h1, v);
         chk($sformatf("R1/R2/R3/R4/R5 vec %0d", k), v, VEC[k][7:0]);
      end

      // R6 strobes
      wr(4'h2, 8'h40);
      chk("R6 dma strobe", {dma_rst, fifo_rst}, 2'b10);
      tick();
      chk("R6 dma strobe ends", {dma_rst, fifo_rst}, 2'b00);
      wr(4'h2, 8'h80);
      chk("R6 fifo strobe", {dma_rst, fifo_rst}, 2'b01);
      tick();
      chk("R6 fifo strobe ends", {dma_rst, fifo_rst}, 2'b00);

      // R7 / R8 transfer count
      wr(4'h8, 8'h03);
      rd_cnt(c); chk("R7 load", c, 3);
      samp = 1'b1; tick();
      samp = 1'b1; tick();
      rd_cnt(c); chk("R7 decrement", c, 1);
      rd(4'h1, v); chk("R8 not yet", v, 8'h00);
      samp = 1'b1; tick();
      rd(4'h1, v); chk("R8 expire", v, 8'h02);
      samp = 1'b1; tick();
      rd_cnt(c); chk("R7 hold zero", c, 0);
      wr(4'h2, 8'h38);
      rd(4'h1, v); chk("R3 expire kept", v, 8'h02);
      wr(4'h3, 8'h01);
      rd(4'h1, v); chk("R4 expire cleared", v, 8'h00);
      wr(4'h9, 8'h01);
      samp = 1'b1; tick();
      rd_cnt(c); chk("R7 borrow", c, 32'hFF);
      rd(4'h1, v); chk("R8 no expire on borrow", v, 8'h00);
      wr(4'h8, 8'h00);
      samp = 1'b1; tick();
      rd(4'h1, v); chk("R8 zero count", v, 8'h00);
      wr(4'h8, 8'h01);
      samp = 1'b1; wr_en = 1'b1; wr_addr = 4'h3; wr_data = 8'h01;
      tick();
      rd(4'h1, v); chk("R5 expire beats clear", v, 8'h02);
      wr(4'h3, 8'h01);

      // R9 / R10 masking and routing
      wr(4'h4, 8'h20);
      wr(4'h5, 8'h01);
      rd(4'h0, v); chk("R9 idle status", v, 8'h00);
      wt = 1'b1; tick();
      rd(4'h0, v); chk("R9 pending", v, 8'h01);
      chk("R10 latency", {29'd0, irq}, 0);
      tick();
      chk("R10 line 1", {29'd0, irq}, 3'b001);
      wr(4'h5, 8'h02);
      tick();
      chk("R10 line 2", {29'd0, irq}, 3'b010);
      wr(4'h5, 8'h00);
      tick();
      chk("R10 disabled", {29'd0, irq}, 0);
      wr(4'h4, 8'h40);
      rd(4'h0, v); chk("R9 masked", v, 8'h00);
      wr(4'h4, 8'h01);
      fifo_ne = 1'b1;
      rd(4'h0, v); chk("R9 ready enabled", v, 8'h01);
      fifo_ne = 1'b0;
      rd(4'h0, v); chk("R1 ready drops", v, 8'h00);
      wr(4'h2, 8'h08);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule